// File: doc/BRIEF.md
# Scalar Accumulator ALU with Register Writeback

This block is the scalar execution datapath of a small load/store accumulator machine. It holds three 32-bit architectural registers (A, X and Y) and two condition flags (carry and zero). Each cycle it can carry out one operation decoded from a 4-bit operation code, two 2-bit source selectors and a 2-bit destination selector, with a 16-bit immediate. The first operand can be a register or the constant zero. The second operand can be a register or the zero-extended immediate. The result goes back into the chosen register, or is dropped when the destination code is 00.

The same operand selectors also drive a base-plus-offset adder, whose sum is always on a port. Load, store and jump logic outside the block uses it as an effective address.

A separate flag command sets or clears carry, zero or both directly. When an ALU operation is issued in the same cycle, the flag command is ignored. Instruction fetch, memory access and branching are handled outside the block.

Top module: `sc_accum_alu`

## Requirements
- R1: After reset is released, A, X and Y read zero, and the carry and zero flags read 0.
- R2: First-source code 00 gives the constant 0. Second-source code 00 gives the immediate, zero-extended to 32 bits. Codes 01, 10 and 11 select A, X and Y for either source.
- R3: Arithmetic codes:
  - 0000 is op1+op2.
  - 0001 is op1+op2+carry.
  - 0010 is op1-op2.
  - 0011 is op1-op2-carry.
  - 0100 is op1+1.
  - 0110 is op1-1.

  Results are modulo 2^32. Carry takes the carry-out of an addition, or the borrow (1 when the true difference is negative) of a subtraction.
- R4: Codes 1000 (AND), 1001 (OR) and 1010 (XOR) combine op1 with op2 bitwise and leave carry unchanged.
- R5: Shift codes act on op1 by one bit:
  - 1100 shifts left with a 0 fill.
  - 1101 shifts left with the old carry filled in.
  - 1110 shifts right with a 0 fill.
  - 1111 shifts right with the old carry filled in at bit 31.

  The bit shifted out (bit 31 for left, bit 0 for right) becomes the new carry.
- R6: Code 1011 yields the low 32 bits of op1*op2 and leaves carry unchanged. When multiply is configured out, 1011 behaves as an unassigned code.
- R7: Destination code 01, 10 or 11 writes the result into A, X or Y at the next clock edge, and the other registers keep their values. Destination code 00 writes no register.
- R8: The zero flag becomes 1 exactly when the 32-bit result is 0. It is updated by every assigned operation with a nonzero destination, and by codes 0000 and 0010 with destination 00. Otherwise it is kept.
- R9: Codes 0101 and 0111 change no register and no flag.
- R10: A flag command with no ALU operation in the same cycle loads the value bit into carry when select bit 0 is set, and into zero when select bit 1 is set. When an ALU operation is issued in the same cycle, the flag command is ignored.
- R11: `addr_out` equals op1+op2 modulo 2^32, combinationally, in every cycle.
- R12: In a cycle with neither an operation nor a flag command, all registers and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue an ALU operation this cycle |
| op_code | input | 4 | Operation code |
| dst_sel | input | 2 | Destination: 00 none, 01 A, 10 X, 11 Y |
| src1_sel | input | 2 | First operand: 00 zero, 01 A, 10 X, 11 Y |
| src2_sel | input | 2 | Second operand: 00 immediate, 01 A, 10 X, 11 Y |
| imm | input | 16 | Immediate, zero-extended |
| flag_valid | input | 1 | Issue a flag command this cycle |
| flag_sel | input | 2 | Bit 0 targets carry, bit 1 targets zero |
| flag_val | input | 1 | Value written to the targeted flags |
| alu_result | output | 32 | Combinational result of the current operation |
| addr_out | output | 32 | Combinational op1+op2 address sum |
| reg_a | output | 32 | Register A |
| reg_x | output | 32 | Register X |
| reg_y | output | 32 | Register Y |
| carry_flag | output | 1 | Carry flag |
| zero_flag | output | 1 | Zero flag |

## Verification
All architectural state is visible on the ports, so a wrong register write, a write to the wrong register, or a wrong flag update shows up one clock edge after the operation that caused it. A wrong operand selection shows up in the same cycle on `addr_out` and `alu_result`, before any state changes. A carry that is corrupted silently is exposed at the latest by the next carry-consuming operation (add-with-carry, subtract-with-borrow or a rotate), because its value then appears in a register. The bench issues every combination of code, destination and sources several times, against a running model of the register file, so such errors propagate and are caught within a few operations.

// File: rtl/sc_alu_pkg.sv
package sc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_ADC  = 4'h1, OP_SUB = 4'h2, OP_SBC = 4'h3,
    OP_INC  = 4'h4, OP_RSV5 = 4'h5, OP_DEC = 4'h6, OP_RSV7 = 4'h7,
    OP_AND  = 4'h8, OP_OR   = 4'h9, OP_XOR = 4'hA, OP_MUL = 4'hB,
    OP_LSL  = 4'hC, OP_ROL  = 4'hD, OP_LSR = 4'hE, OP_ROR = 4'hF
  } alu_op_e;

  localparam int NUM_ARCH_REGS = 3;
  localparam int SEL_W         = 2;

  function automatic logic op_is_legal(input logic [3:0] op, input logic has_mul);
    return !(op == OP_RSV5 || op == OP_RSV7) && (op != OP_MUL || has_mul);
  endfunction

  // arithmetic group (upper bit clear) and shift group write carry
  function automatic logic op_sets_carry(input logic [3:0] op);
    return (op[3] == 1'b0) || (op[3:2] == 2'b11);
  endfunction

  // compare-style operations update zero even when the result is dropped
  function automatic logic op_zero_when_dropped(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/sc_opnd_sel.sv
module sc_opnd_sel #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] code0_val,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_x,
  input  logic [DATA_W-1:0] reg_y,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (sel)
      2'b00:   opnd = code0_val;
      2'b01:   opnd = reg_a;
      2'b10:   opnd = reg_x;
      default: opnd = reg_y;
    endcase
  end
endmodule

// File: rtl/sc_alu_exec.sv
module sc_alu_exec
  import sc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit HAS_MUL = 1'b1
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] op1,
  input  logic [DATA_W-1:0] op2,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic [DATA_W-1:0] base_sum
);
  localparam int EXT_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  function automatic logic [DATA_W:0] add_ext(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b,
                                              input logic cin);
    return {1'b0, a} + {1'b0, b} + EXT_W'(cin);
  endfunction

  // top bit of the extended difference is the borrow
  function automatic logic [DATA_W:0] sub_ext(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b,
                                              input logic bin);
    return {1'b0, a} - {1'b0, b} - EXT_W'(bin);
  endfunction

  logic [DATA_W:0]   sum_plain, sum_c, sum_inc, dif_plain, dif_b, dif_dec;
  logic [DATA_W-1:0] product;

  assign sum_plain = add_ext(op1, op2, 1'b0);
  assign sum_c     = add_ext(op1, op2, carry_in);
  assign sum_inc   = add_ext(op1, ONE, 1'b0);
  assign dif_plain = sub_ext(op1, op2, 1'b0);
  assign dif_b     = sub_ext(op1, op2, carry_in);
  assign dif_dec   = sub_ext(op1, ONE, 1'b0);
  assign base_sum  = sum_plain[DATA_W-1:0];

  generate
    if (HAS_MUL) begin : g_mul
      assign product = op1 * op2;
    end else begin : g_no_mul
      assign product = '0;
    end
  endgenerate

  always_comb begin
    result    = '0;
    carry_out = carry_in;
    unique case (op)
      OP_ADD: {carry_out, result} = sum_plain;
      OP_ADC: {carry_out, result} = sum_c;
      OP_SUB: {carry_out, result} = dif_plain;
      OP_SBC: {carry_out, result} = dif_b;
      OP_INC: {carry_out, result} = sum_inc;
      OP_DEC: {carry_out, result} = dif_dec;
      OP_AND: result = op1 & op2;
      OP_OR:  result = op1 | op2;
      OP_XOR: result = op1 ^ op2;
      OP_MUL: result = product;
      OP_LSL: begin result = {op1[DATA_W-2:0], 1'b0};     carry_out = op1[DATA_W-1]; end
      OP_ROL: begin result = {op1[DATA_W-2:0], carry_in}; carry_out = op1[DATA_W-1]; end
      OP_LSR: begin result = {1'b0, op1[DATA_W-1:1]};     carry_out = op1[0];        end
      OP_ROR: begin result = {carry_in, op1[DATA_W-1:1]}; carry_out = op1[0];        end
      default: begin result = '0; carry_out = carry_in; end
    endcase
  end
endmodule

// File: rtl/sc_arch_state.sv
module sc_arch_state
  import sc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_ARCH_REGS-1:0]        wr_en,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            carry_we,
  input  logic                            carry_d,
  input  logic                            zero_we,
  input  logic                            zero_d,
  output logic [NUM_ARCH_REGS*DATA_W-1:0] regs_flat,
  output logic                            carry_q,
  output logic                            zero_q
);
  generate
    for (genvar i = 0; i < NUM_ARCH_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (wr_en[i]) q <= wr_data;
      end
      assign regs_flat[i*DATA_W +: DATA_W] = q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (carry_we) carry_q <= carry_d;
      if (zero_we)  zero_q  <= zero_d;
    end
  end
endmodule

// File: rtl/sc_accum_alu.sv
module sc_accum_alu
  import sc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter bit HAS_MUL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [1:0]        dst_sel,
  input  logic [1:0]        src1_sel,
  input  logic [1:0]        src2_sel,
  input  logic [IMM_W-1:0]  imm,
  input  logic              flag_valid,
  input  logic [1:0]        flag_sel,
  input  logic              flag_val,
  output logic [DATA_W-1:0] alu_result,
  output logic [DATA_W-1:0] addr_out,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_x,
  output logic [DATA_W-1:0] reg_y,
  output logic              carry_flag,
  output logic              zero_flag
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0]               imm_ext, op1, op2, exec_res;
  logic [NUM_ARCH_REGS*DATA_W-1:0] regs_flat;
  logic                            exec_carry, op_fire, flag_fire;
  logic [NUM_ARCH_REGS-1:0]        wr_en;
  logic                            carry_we, carry_d, zero_we, zero_d;

  assign imm_ext = {{PAD_W{1'b0}}, imm};
  assign reg_a   = regs_flat[0*DATA_W +: DATA_W];
  assign reg_x   = regs_flat[1*DATA_W +: DATA_W];
  assign reg_y   = regs_flat[2*DATA_W +: DATA_W];

  sc_opnd_sel #(.DATA_W(DATA_W)) u_src1 (
    .sel(src1_sel), .code0_val('0), .reg_a(reg_a), .reg_x(reg_x),
    .reg_y(reg_y), .opnd(op1));

  sc_opnd_sel #(.DATA_W(DATA_W)) u_src2 (
    .sel(src2_sel), .code0_val(imm_ext), .reg_a(reg_a), .reg_x(reg_x),
    .reg_y(reg_y), .opnd(op2));

  sc_alu_exec #(.DATA_W(DATA_W), .HAS_MUL(HAS_MUL)) u_exec (
    .op(op_code), .op1(op1), .op2(op2), .carry_in(carry_flag),
    .result(exec_res), .carry_out(exec_carry), .base_sum(addr_out));

  assign alu_result = exec_res;
  assign op_fire    = op_valid && op_is_legal(op_code, HAS_MUL);
  assign flag_fire  = flag_valid && !op_valid;

  generate
    for (genvar i = 0; i < NUM_ARCH_REGS; i++) begin : g_wr
      assign wr_en[i] = op_fire && (dst_sel == SEL_W'(i + 1));
    end
  endgenerate

  assign carry_we = (op_fire && op_sets_carry(op_code)) || (flag_fire && flag_sel[0]);
  assign carry_d  = op_fire ? exec_carry : flag_val;
  assign zero_we  = (op_fire && ((dst_sel != 2'b00) || op_zero_when_dropped(op_code)))
                 || (flag_fire && flag_sel[1]);
  assign zero_d   = op_fire ? (exec_res == '0) : flag_val;

  sc_arch_state #(.DATA_W(DATA_W)) u_state (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(exec_res),
    .carry_we(carry_we), .carry_d(carry_d), .zero_we(zero_we), .zero_d(zero_d),
    .regs_flat(regs_flat), .carry_q(carry_flag), .zero_q(zero_flag));
endmodule

// File: rtl/sc_accum_alu_chk.sv
module sc_accum_alu_chk
  import sc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter bit HAS_MUL = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     op_valid,
  input logic [3:0]               op_code,
  input logic [1:0]               dst_sel,
  input logic [1:0]               src1_sel,
  input logic [1:0]               src2_sel,
  input logic [IMM_W-1:0]         imm,
  input logic                     flag_valid,
  input logic [1:0]               flag_sel,
  input logic                     flag_val,
  input logic [DATA_W-1:0]        addr_out,
  input logic [DATA_W-1:0]        reg_a,
  input logic [DATA_W-1:0]        reg_x,
  input logic [DATA_W-1:0]        reg_y,
  input logic                     carry_flag,
  input logic                     zero_flag,
  input logic [NUM_ARCH_REGS-1:0] wr_en
);
  logic all_stable_unused;
  assign all_stable_unused = 1'b0;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !flag_valid) |=> ($stable(reg_a) && $stable(reg_x) && $stable(reg_y)
      && $stable(carry_flag) && $stable(zero_flag))); // R12

  AST_DROPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dst_sel == 2'b00) |=> ($stable(reg_a) && $stable(reg_x) && $stable(reg_y))); // R7

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R7

  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
      |=> $stable(carry_flag)); // R4

  AST_RESERVED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_RSV5 || op_code == OP_RSV7)) |=> ($stable(reg_a)
      && $stable(reg_x) && $stable(reg_y) && $stable(carry_flag) && $stable(zero_flag))); // R9

  AST_ZERO_MATCHES_A: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_is_legal(op_code, HAS_MUL) && dst_sel == 2'b01)
      |=> (zero_flag == (reg_a == '0))); // R8

  AST_FLAG_LOADS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && !op_valid && flag_sel[0]) |=> (carry_flag == $past(flag_val))); // R10

  AST_IMM_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (src1_sel == 2'b00 && src2_sel == 2'b00) |-> (addr_out == DATA_W'(imm))); // R11
endmodule

bind sc_accum_alu sc_accum_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .HAS_MUL(HAS_MUL)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .dst_sel(dst_sel),
  .src1_sel(src1_sel), .src2_sel(src2_sel), .imm(imm), .flag_valid(flag_valid),
  .flag_sel(flag_sel), .flag_val(flag_val), .addr_out(addr_out), .reg_a(reg_a),
  .reg_x(reg_x), .reg_y(reg_y), .carry_flag(carry_flag), .zero_flag(zero_flag),
  .wr_en(wr_en));

// File: tb/sim_sc_accum_alu.sv
module sim_sc_accum_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [1:0]  dst_sel = '0, src1_sel = '0, src2_sel = '0;
  logic [15:0] imm = '0;
  logic        flag_valid = 1'b0;
  logic [1:0]  flag_sel = '0;
  logic        flag_val = 1'b0;
  logic [31:0] alu_result, addr_out, reg_a, reg_x, reg_y;
  logic        carry_flag, zero_flag;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_a = '0, m_x = '0, m_y = '0;
  logic        m_c = 1'b0, m_z = 1'b0;
  logic [31:0] rng = 32'h1bad5eed;

  always #2 clk = ~clk;   // 4 ns period

  sc_accum_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst_sel(dst_sel), .src1_sel(src1_sel), .src2_sel(src2_sel), .imm(imm),
    .flag_valid(flag_valid), .flag_sel(flag_sel), .flag_val(flag_val),
    .alu_result(alu_result), .addr_out(addr_out), .reg_a(reg_a), .reg_x(reg_x),
    .reg_y(reg_y), .carry_flag(carry_flag), .zero_flag(zero_flag));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] zero_case);
    case (s)
      2'd1: return m_a;
      2'd2: return m_x;
      2'd3: return m_y;
      default: return zero_case;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    if (op == 4'd5 || op == 4'd7) return "R9";
    if (op == 4'd11) return "R6";
    if (op >= 4'd12) return "R5";
    if (op >= 4'd8) return "R4";
    return "R3";
  endfunction

  // expected result of one operation, written as two's-complement sums
  task automatic predict(input logic [3:0] op, input logic [31:0] p, input logic [31:0] q,
                         input logic c, output logic [31:0] r, output logic nc,
                         output logic ok, output logic wc);
    logic [32:0] t;
    logic [63:0] pr;
    ok = 1'b1; wc = 1'b1; nc = c; r = '0;
    case (op)
      4'd0:  begin t = {1'b0,p} + {1'b0,q};                r = t[31:0]; nc = t[32];  end
      4'd1:  begin t = {1'b0,p} + {1'b0,q} + {32'd0,c};    r = t[31:0]; nc = t[32];  end
      4'd2:  begin t = {1'b0,p} + {1'b0,~q} + 33'd1;       r = t[31:0]; nc = ~t[32]; end
      4'd3:  begin t = {1'b0,p} + {1'b0,~q} + {32'd0,~c};  r = t[31:0]; nc = ~t[32]; end
      4'd4:  begin t = {1'b0,p} + 33'd1;                   r = t[31:0]; nc = t[32];  end
      4'd6:  begin t = {1'b0,p} + 33'h0ffffffff;           r = t[31:0]; nc = ~t[32]; end
      4'd8:  begin r = p & q; wc = 1'b0; end
      4'd9:  begin r = p | q; wc = 1'b0; end
      4'd10: begin r = p ^ q; wc = 1'b0; end
      4'd11: begin pr = {32'd0,p} * {32'd0,q}; r = pr[31:0]; wc = 1'b0; end
      4'd12: begin r = p << 1;                   nc = p[31]; end
      4'd13: begin r = (p << 1) | {31'd0,c};     nc = p[31]; end
      4'd14: begin r = p >> 1;                   nc = p[0];  end
      4'd15: begin r = (p >> 1) | {c, 31'd0};    nc = p[0];  end
      default: begin ok = 1'b0; wc = 1'b0; end
    endcase
  endtask

  task automatic apply(input string tag, input logic v, input logic [3:0] op,
                       input logic [1:0] d, input logic [1:0] s1, input logic [1:0] s2,
                       input logic [15:0] im, input logic fv, input logic [1:0] fs,
                       input logic fval);
    logic [31:0] p, q, r;
    logic nc, ok, wc;
    @(negedge clk);
    op_valid = v; op_code = op; dst_sel = d; src1_sel = s1; src2_sel = s2; imm = im;
    flag_valid = fv; flag_sel = fs; flag_val = fval;
    #1;
    p = pick(s1, 32'd0);
    q = pick(s2, {16'd0, im});
    chk("R11 R2", "addr_out", addr_out, p + q);
    predict(op, p, q, m_c, r, nc, ok, wc);
    if (v && ok) begin
      chk(tag, "alu_result", alu_result, r);
      case (d)
        2'd1: m_a = r;
        2'd2: m_x = r;
        2'd3: m_y = r;
        default: ;
      endcase
      if (wc) m_c = nc;
      if (d != 2'd0 || op == 4'd0 || op == 4'd2) m_z = (r == 32'd0);
    end else if (!v && fv) begin
      if (fs[0]) m_c = fval;
      if (fs[1]) m_z = fval;
    end
    @(posedge clk);
    #1;
    chk({tag, " R7"}, "reg_a", reg_a, m_a);
    chk({tag, " R7"}, "reg_x", reg_x, m_x);
    chk({tag, " R7"}, "reg_y", reg_y, m_y);
    chk(tag, "carry", {31'd0, carry_flag}, {31'd0, m_c});
    chk({tag, " R8"}, "zero", {31'd0, zero_flag}, {31'd0, m_z});
  endtask

  task automatic reseed();
    rng = next_rng(rng);
    apply("R2", 1'b1, 4'd0, 2'd1, 2'd0, 2'd0, rng[15:0], 1'b0, 2'd0, 1'b0);
    apply("R2", 1'b1, 4'd0, 2'd2, 2'd0, 2'd0, rng[31:16] | 16'h8001, 1'b0, 2'd0, 1'b0);
    apply("R6", 1'b1, 4'd11, 2'd3, 2'd1, 2'd2, 16'd0, 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset values
    chk("R1", "reg_a", reg_a, 32'd0);
    chk("R1", "reg_x", reg_x, 32'd0);
    chk("R1", "reg_y", reg_y, 32'd0);
    chk("R1", "carry", {31'd0, carry_flag}, 32'd0);
    chk("R1", "zero", {31'd0, zero_flag}, 32'd0);

    // R3 borrow and carry corners: 0-1 then wrap back with INC
    apply("R3", 1'b1, 4'd6, 2'd1, 2'd0, 2'd0, 16'd0, 1'b0, 2'd0, 1'b0);
    apply("R3", 1'b1, 4'd4, 2'd2, 2'd1, 2'd0, 16'd0, 1'b0, 2'd0, 1'b0);
    apply("R3", 1'b1, 4'd0, 2'd3, 2'd1, 2'd1, 16'd0, 1'b0, 2'd0, 1'b0);
    // R5 rotates through a known carry
    apply("R10", 1'b0, 4'd0, 2'd0, 2'd0, 2'd0, 16'd0, 1'b1, 2'b01, 1'b1);
    apply("R5", 1'b1, 4'd15, 2'd2, 2'd2, 2'd0, 16'd0, 1'b0, 2'd0, 1'b0);
    apply("R5", 1'b1, 4'd13, 2'd2, 2'd2, 2'd0, 16'd0, 1'b0, 2'd0, 1'b0);
    // R8 compare with dropped result, then dropped logic keeps zero
    apply("R8", 1'b1, 4'd2, 2'd0, 2'd1, 2'd1, 16'd0, 1'b0, 2'd0, 1'b0);
    apply("R8", 1'b1, 4'd9, 2'd0, 2'd1, 2'd0, 16'd7, 1'b0, 2'd0, 1'b0);
    // R9 unassigned codes with a live destination
    apply("R9", 1'b1, 4'd5, 2'd1, 2'd0, 2'd0, 16'h1234, 1'b0, 2'd0, 1'b0);
    apply("R9", 1'b1, 4'd7, 2'd3, 2'd2, 2'd0, 16'h0042, 1'b0, 2'd0, 1'b0);
    // R10 flag commands on each flag, then ignored under an operation
    apply("R10", 1'b0, 4'd0, 2'd0, 2'd0, 2'd0, 16'd0, 1'b1, 2'b11, 1'b1);
    apply("R10", 1'b0, 4'd0, 2'd0, 2'd0, 2'd0, 16'd0, 1'b1, 2'b10, 1'b0);
    apply("R10", 1'b0, 4'd0, 2'd0, 2'd0, 2'd0, 16'd0, 1'b1, 2'b01, 1'b0);
    apply("R10", 1'b1, 4'd0, 2'd0, 2'd0, 2'd0, 16'd5, 1'b1, 2'b11, 1'b1);
    // R12 idle cycles
    for (int k = 0; k < 4; k++)
      apply("R12", 1'b0, 4'd0, 2'd0, 2'd0, 2'd0, 16'hffff, 1'b0, 2'b11, 1'b1);

    // full sweep of code x destination x both sources, four passes
    for (int pass = 0; pass < 4; pass++) begin
      for (int op = 0; op < 16; op++) begin
        for (int d = 0; d < 4; d++) begin
          reseed();
          apply("R10", 1'b0, 4'd0, 2'd0, 2'd0, 2'd0, 16'd0, 1'b1, 2'b01, rng[3]);
          for (int s1 = 0; s1 < 4; s1++) begin
            for (int s2 = 0; s2 < 4; s2++) begin
              rng = next_rng(rng);
              apply(tag_of(4'(op)), 1'b1, 4'(op), 2'(d), 2'(s1), 2'(s2),
                    rng[15:0], 1'b0, 2'd0, 1'b0);
            end
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule